// File: doc/BRIEF.md
# Cross-Clock One-Word Mailbox Bypass

This block carries single 18-bit messages from a controlling agent on clock A to a peer on clock B. It bypasses any FIFO storage. The controller alone decides when a bypass session starts and stops, using a port-select input and a mode-select input. The peer sees a mode indicator registered on its own clock, so it can tell a bypass session from ordinary FIFO traffic.

Each direction behaves as a mailbox one word deep. A controller write fills a holding register and raises a busy flag on the controller's side. The peer then sees a word-available flag. Its read moves the word into the peer's output register, and the busy flag clears once that read has crossed back into clock A. Write and read events cross the two domains as toggles, so no event is lost and none is counted twice.

The controller may leave bypass while a word is still pending. In that case the peer has exactly the clock-B cycle in which its mode indicator is still set to take the word. After that the word is discarded, and reads load the ordinary FIFO word into the output register instead. The handshake then settles back to idle, ready for a new session. The opposite direction is a second instance of this block with the roles swapped.

Top module: `xclk_mailbox`

## Requirements
- R1: After reset, a_full, b_avail and b_byp_on are 0 and b_q is all zeros.
- R2: b_byp_on is 1 after any clk_b edge that samples a_sel=1 and a_byp=1. It is 0 after any clk_b edge that samples either of them low.
- R3: A clk_a edge with a_sel=1, a_byp=1, a_wr=1 and a_full=0 stores a_data as the pending word. a_full reads 1 directly after that edge.
- R4: A write attempt while a_full=1, or while a_sel or a_byp is 0, is ignored. The pending word stays as it was, and a write with bypass not selected leaves a_full at 0.
- R5: With SYNC_STAGES=2, b_avail is still 0 after the first clk_b edge that follows an accepted write. It is 1 after the second such edge, while b_byp_on stays 1.
- R6: A clk_b edge with b_rd=1 and b_avail=1 loads the pending word into b_q, and b_avail reads 0 after that edge.
- R7: After a consuming read, a_full is still 1 after the first clk_a edge that follows the read edge. It is 0 after the second such edge.
- R8: A read taken while b_byp_on is still 1 on the controller's exit delivers the pending word. Once b_byp_on has fallen, b_avail is 0 and a read with b_rd=1 loads b_fifo_word into b_q in place of the pending word.
- R9: After a forced exit, a_full returns to 0 without any peer read. A new session does not deliver the discarded word; it delivers only the words written after re-entry.
- R10: b_avail is never 1 while b_byp_on is 0.
- R11: A read with b_rd=1 while b_byp_on=1 and b_avail=0 leaves b_q unchanged.
- R12: Over a session with back-to-back traffic, every accepted word reaches b_q exactly once, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Controller clock |
| rst_a | input | 1 | Synchronous active-high reset, clock A domain |
| a_sel | input | 1 | Controller port selected |
| a_byp | input | 1 | Mode select: 1 requests bypass, 0 normal FIFO mode |
| a_wr | input | 1 | Controller write strobe |
| a_data | input | WORD_W | Message word from the controller |
| a_full | output | 1 | A message is pending; further writes are blocked |
| clk_b | input | 1 | Peer clock |
| rst_b | input | 1 | Synchronous active-high reset, clock B domain |
| b_rd | input | 1 | Peer read strobe |
| b_fifo_word | input | WORD_W | Word from the normal FIFO path, loaded on reads outside bypass |
| b_byp_on | output | 1 | Bypass mode indicator registered on clk_b |
| b_avail | output | 1 | A bypass word is waiting for the peer |
| b_q | output | WORD_W | Peer output register |

## Verification
The sharpest case is a forced exit while a word is pending. A design that gave the peer no last cycle would drop a word that was read in time. A design that never discarded the word would let it appear in b_q, or reappear in the next session, in place of the FIFO word. A second case is the latency of the flags across the two clocks. A synchronizer one stage short would raise b_avail or clear a_full an edge early, and a missing toggle compare would leave a_full stuck after the exit. Random traffic that mixes write attempts while busy with read attempts while nothing is waiting exposes a design that overwrites the pending word, moves b_q on a blocked read, or delivers a word twice or out of order.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_WORD_W   = 18;
    localparam int unsigned MBX_SYNC_DEF = 2;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_BYPASS = 2'd1,
        RD_FIFO   = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic sel;
        logic byp;
        logic wr;
    } ctl_a_t;

    function automatic logic byp_selected(input ctl_a_t c);
        return c.sel & c.byp;
    endfunction

    function automatic rd_kind_e rd_classify(input logic mode,
                                             input logic rd,
                                             input logic avail);
        if (!rd)   return RD_NONE;
        if (!mode) return RD_FIFO;
        if (avail) return RD_BYPASS;
        return RD_NONE;
    endfunction

endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic dout_pre
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign dout     = chain[LAST];
    assign dout_pre = chain[LAST-1];
endmodule

// File: rtl/mbx_send.sv
module mbx_send
    import mbx_pkg::*;
#(
    parameter int unsigned WORD_W = MBX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_a_t            ctl,
    input  logic [WORD_W-1:0] data,
    input  logic              ack_seen,
    output logic              full,
    output logic              wr_tog,
    output logic [WORD_W-1:0] hold
);
    logic accept;

    assign full   = wr_tog ^ ack_seen;
    assign accept = byp_selected(ctl) & ctl.wr & ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_tog <= 1'b0;
            hold   <= '0;
        end else if (accept) begin
            wr_tog <= ~wr_tog;
            hold   <= data;
        end
    end

    assert_write_sets_full_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> full);

    assert_busy_keeps_word_R4: assert property (@(posedge clk) disable iff (rst)
        (full && ctl.wr) |=> $stable(hold));

    assert_idle_mode_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!byp_selected(ctl) && !full) |=> !full);
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv
    import mbx_pkg::*;
#(
    parameter int unsigned WORD_W = MBX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_a_t            ctl,
    input  logic              rd,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              wr_seen,
    input  logic              wr_seen_next,
    input  logic [WORD_W-1:0] hold,
    output logic              mode,
    output logic              avail,
    output logic              ack_tog,
    output logic [WORD_W-1:0] q
);
    rd_kind_e kind;
    logic     pend;

    assign pend  = wr_seen ^ ack_tog;
    assign avail = mode & pend;
    assign kind  = rd_classify(mode, rd, avail);

    always_ff @(posedge clk) begin
        if (rst) mode <= 1'b0;
        else     mode <= byp_selected(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_tog <= 1'b0;
        end else if (!mode) begin
            ack_tog <= wr_seen_next;
        end else if (kind == RD_BYPASS) begin
            ack_tog <= ~ack_tog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (kind)
                RD_BYPASS: q <= hold;
                RD_FIFO:   q <= fifo_word;
                default:   q <= q;
            endcase
        end
    end

    assert_mode_on_R2: assert property (@(posedge clk) disable iff (rst)
        byp_selected(ctl) |=> mode);

    assert_mode_off_R2: assert property (@(posedge clk) disable iff (rst)
        !byp_selected(ctl) |=> !mode);

    assert_read_clears_avail_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && avail) |=> !avail);

    assert_read_delivers_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && avail) |=> (q == $past(hold)));

    assert_blocked_read_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && mode && !avail) |=> $stable(q));
endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned WORD_W      = MBX_WORD_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_sel,
    input  logic              a_byp,
    input  logic              a_wr,
    input  logic [WORD_W-1:0] a_data,
    output logic              a_full,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_rd,
    input  logic [WORD_W-1:0] b_fifo_word,
    output logic              b_byp_on,
    output logic              b_avail,
    output logic [WORD_W-1:0] b_q
);
    ctl_a_t            ctl;
    logic              wr_tog, ack_tog;
    logic              wr_seen, wr_seen_next;
    logic              ack_seen, ack_seen_next;
    logic [WORD_W-1:0] hold;

    assign ctl = '{sel: a_sel, byp: a_byp, wr: a_wr};

    mbx_send #(.WORD_W(WORD_W)) u_send (
        .clk      (clk_a),
        .rst      (rst_a),
        .ctl      (ctl),
        .data     (a_data),
        .ack_seen (ack_seen),
        .full     (a_full),
        .wr_tog   (wr_tog),
        .hold     (hold)
    );

    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk      (clk_b),
        .rst      (rst_b),
        .din      (wr_tog),
        .dout     (wr_seen),
        .dout_pre (wr_seen_next)
    );

    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (clk_a),
        .rst      (rst_a),
        .din      (ack_tog),
        .dout     (ack_seen),
        .dout_pre (ack_seen_next)
    );

    mbx_recv #(.WORD_W(WORD_W)) u_recv (
        .clk          (clk_b),
        .rst          (rst_b),
        .ctl          (ctl),
        .rd           (b_rd),
        .fifo_word    (b_fifo_word),
        .wr_seen      (wr_seen),
        .wr_seen_next (wr_seen_next),
        .hold         (hold),
        .mode         (b_byp_on),
        .avail        (b_avail),
        .ack_tog      (ack_tog),
        .q            (b_q)
    );

    logic unused_ack_next;
    assign unused_ack_next = ack_seen_next;

    assert_avail_needs_mode_R10: assert property (@(posedge clk_b) disable iff (rst_b)
        $rose(b_avail) |-> (b_byp_on && $stable(b_byp_on)));
endmodule

// File: tb/tb_xclk_mailbox.sv
module tb_xclk_mailbox;
    timeunit 1ns;
    timeprecision 10ps;

    localparam int W = 18;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a = 1'b1, rst_b = 1'b1;
    logic         a_sel = 1'b0, a_byp = 1'b0, a_wr = 1'b0, b_rd = 1'b0;
    logic [W-1:0] a_data = '0, b_fifo_word = '0;
    logic         a_full, b_byp_on, b_avail;
    logic [W-1:0] b_q;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [W-1:0] exp_q[$];

    xclk_mailbox dut (
        .clk_a(clk_a), .rst_a(rst_a), .a_sel(a_sel), .a_byp(a_byp), .a_wr(a_wr),
        .a_data(a_data), .a_full(a_full), .clk_b(clk_b), .rst_b(rst_b), .b_rd(b_rd),
        .b_fifo_word(b_fifo_word), .b_byp_on(b_byp_on), .b_avail(b_avail), .b_q(b_q)
    );

    always #2.5 clk_a = ~clk_a;
    initial begin
        #1.3;
        forever begin clk_b = 1'b1; #3.5; clk_b = 1'b0; #3.5; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic a_tick(); @(posedge clk_a); #1; endtask
    task automatic b_tick(); @(posedge clk_b); #1; endtask

    task automatic wait_avail();
        for (int i = 0; i < 12 && !b_avail; i++) b_tick();
    endtask

    task automatic a_write(input logic [W-1:0] d);
        a_tick();
        a_data = d; a_wr = 1'b1;
        a_tick();
        a_wr = 1'b0;
    endtask

    task automatic b_read();
        b_rd = 1'b1;
        b_tick();
        b_rd = 1'b0;
    endtask

    function automatic logic [W-1:0] pick_word(input logic [31:0] r);
        return r[W-1:0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w1, w2, w3, f;
        void'($urandom(32'd7));
        repeat (3) a_tick(); rst_a = 1'b0;
        repeat (3) b_tick(); rst_b = 1'b0;
        b_tick();
        chk(a_full == 0,   "R1 a_full",   a_full, 0);
        chk(b_avail == 0,  "R1 b_avail",  b_avail, 0);
        chk(b_byp_on == 0, "R1 b_byp_on", b_byp_on, 0);
        chk(b_q == 0,      "R1 b_q",      b_q, 0);

        a_sel = 1'b1; a_byp = 1'b1;
        b_tick();
        chk(b_byp_on == 1, "R2 enter", b_byp_on, 1);

        a_write(18'h2A5C3);
        chk(a_full == 1, "R3 busy after write", a_full, 1);
        b_tick();
        chk(b_avail == 0, "R5 first edge", b_avail, 0);
        b_tick();
        chk(b_avail == 1, "R5 second edge", b_avail, 1);
        a_write(18'h1FFFF);
        chk(a_full == 1, "R4 busy write blocked", a_full, 1);
        b_tick();
        b_read();
        chk(b_q == 18'h2A5C3, "R6 data", b_q, 18'h2A5C3);
        chk(b_avail == 0, "R6 avail cleared", b_avail, 0);
        a_tick();
        chk(a_full == 1, "R7 first A edge", a_full, 1);
        a_tick();
        chk(a_full == 0, "R7 second A edge", a_full, 0);

        b_tick();
        b_read();
        chk(b_q == 18'h2A5C3, "R11 blocked read", b_q, 18'h2A5C3);
        repeat (6) b_tick();
        chk(b_avail == 0, "R4 junk write not delivered", b_avail, 0);

        a_tick();
        a_byp = 1'b0;
        a_write(18'h0F0F0);
        chk(a_full == 0, "R4 write outside bypass", a_full, 0);
        b_tick();
        chk(b_byp_on == 0, "R2 leave", b_byp_on, 0);
        repeat (4) b_tick();
        chk(b_avail == 0, "R10 no avail outside bypass", b_avail, 0);
        a_sel = 1'b0; a_byp = 1'b1;
        b_tick();
        chk(b_byp_on == 0, "R2 deselected", b_byp_on, 0);
        a_sel = 1'b1;
        repeat (2) b_tick();

        w1 = 18'h11111;
        a_write(w1);
        wait_avail();
        chk(b_avail == 1, "R8 session word pending", b_avail, 1);
        a_byp = 1'b0;
        b_read();
        chk(b_q == w1, "R8 last-cycle read", b_q, w1);
        chk(b_byp_on == 0, "R2 exit seen", b_byp_on, 0);
        repeat (10) a_tick();
        chk(a_full == 0, "R9 busy freed after last read", a_full, 0);

        a_byp = 1'b1;
        repeat (2) b_tick();
        w2 = 18'h22222; f = 18'h3C3C3;
        a_write(w2);
        wait_avail();
        a_byp = 1'b0;
        b_tick();
        chk(b_byp_on == 0, "R8 mode fallen", b_byp_on, 0);
        chk(b_avail == 0,  "R8 avail dropped", b_avail, 0);
        b_fifo_word = f;
        b_read();
        chk(b_q == f, "R8 fifo word overwrites", b_q, f);
        repeat (20) a_tick();
        chk(a_full == 0, "R9 busy freed by exit", a_full, 0);
        a_byp = 1'b1;
        repeat (4) b_tick();
        chk(b_avail == 0, "R9 discarded word gone", b_avail, 0);
        w3 = 18'h33333;
        a_write(w3);
        wait_avail();
        b_read();
        chk(b_q == w3, "R9 new session word", b_q, w3);
        repeat (4) a_tick();

        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    logic [W-1:0] d;
                    repeat ($urandom_range(0, 3)) a_tick();
                    for (int k = 0; k < 200 && a_full; k++) a_tick();
                    d = pick_word($urandom);
                    a_data = d; a_wr = 1'b1;
                    a_tick();
                    a_wr = 1'b0;
                    exp_q.push_back(d);
                    if ($urandom_range(0, 1) == 1) begin
                        a_data = ~d; a_wr = 1'b1;
                        a_tick();
                        a_wr = 1'b0;
                    end
                end
            end
            begin
                int got = 0;
                while (got < 40) begin
                    b_tick();
                    if (b_avail && $urandom_range(0, 2) != 0) begin
                        logic [W-1:0] e;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                        b_read();
                        chk(b_q == e, "R12 order", b_q, e);
                        got++;
                    end else if (!b_avail && $urandom_range(0, 4) == 0) begin
                        logic [W-1:0] prev;
                        prev = b_q;
                        b_read();
                        chk(b_q == prev, "R11 random blocked read", b_q, prev);
                    end
                end
            end
        join
        repeat (8) b_tick();
        chk(exp_q.size() == 0, "R12 all delivered", exp_q.size(), 0);
        chk(b_avail == 0, "R12 no duplicate", b_avail, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule